// File: doc/BRIEF.md
# Two-Level Hot Page Tracker

This block watches a stream of page-access events and, over a fixed monitoring period, keeps the pages that are being used most often. A primary table holds the current hot-page candidates. Each candidate has an access counter. A secondary table holds other recently seen pages in recency order, with their own counters. When a secondary page's counter catches up with the weakest primary candidate, the two pages trade places.

An end-of-period pulse starts a report. The block sends out the primary table's pages one per cycle, with a valid strobe and a flag on the final beat. It then zeroes every counter but keeps the pages where they are. A surrounding migration engine uses each report to decide which pages belong in fast memory.

Each access is handled completely before the next one is taken. A `ready` output goes low while an update or a report is in progress.

Top module: `hot_page_tracker`

## Requirements
- R1: After synchronous reset both tables are empty and `ready` is 1 with `rpt_valid` at 0. An end-of-period pulse while the primary table is empty produces no report beat, and `ready` stays high.
- R2: A page that is in no table while the primary table has a free slot goes into the lowest free slot with a count of one. The report lists primary slots from slot 0 upward.
- R3: An access to a page already in the primary table increases that page's count by one and changes nothing else.
- R4: When the primary table is full, a page found in neither table enters the secondary table at the most-recent position with a count of one. If the secondary table is already full, its least-recent entry is dropped first.
- R5: When the primary table is full, an access to a page held in the secondary table increases its count by one and moves it to the most-recent position.
- R6: After every secondary update, the page's count is compared with the smallest primary count. If it is greater or equal, the page takes that primary slot with its count, and the displaced page and its count take the most-recent secondary position. Among equal minimum counts, the lowest slot index is displaced.
- R7: A report starts one cycle after an accepted end-of-period pulse. It emits one beat per occupied primary slot on consecutive cycles, and `rpt_last` is high only on the final beat.
- R8: After a report, all counters in both tables are zero and every page keeps its slot and recency position.
- R9: Counters saturate at their all-ones value and never wrap.
- R10: An access is accepted only when `acc_valid` and `ready` are both high and `period_end` is low. After an accepted access, `ready` is low for exactly one cycle. `ready` is low while report beats other than the final one are sent. When `period_end` and `acc_valid` arrive together, the access is not accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access event strobe |
| acc_page | input | PAGE_W | Page number of the access |
| period_end | input | 1 | End-of-period pulse, takes priority over an access |
| ready | output | 1 | Block can take an access or an end-of-period pulse |
| rpt_valid | output | 1 | Report beat valid |
| rpt_page | output | PAGE_W | Reported primary page |
| rpt_last | output | 1 | Final beat of the report |

## Verification
The bench uses small tables and 4-bit counters so that the edge cases are reachable. A design that wraps its counters would let a barely used secondary page push out a heavily used primary one, and the saturation case exposes this. A design that does not move a secondary hit to the most-recent position would evict that page before it can be promoted. One that breaks ties at the wrong slot, or keeps counts across a period, would displace a different primary page than expected. The bench also sends a simultaneous end-of-period and access, where a design that takes the access would report an extra page. Random traffic over a small page pool, with periodic reports, is compared against a bench model of the table rules.

// File: rtl/hpt_pkg.sv
package hpt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_UPD  = 2'd1,
    ST_RPT  = 2'd2
  } hpt_state_t;
endpackage

// File: rtl/hpt_match.sv
// Associative lookup over the occupied part of a table.
module hpt_match #(
  parameter int N      = 8,
  parameter int PAGE_W = 20,
  localparam int IW    = (N > 1) ? $clog2(N) : 1,
  localparam int FW    = $clog2(N + 1)
) (
  input  logic [N-1:0][PAGE_W-1:0] pages,
  input  logic [FW-1:0]            fill,
  input  logic [PAGE_W-1:0]        key,
  output logic                     hit,
  output logic [IW-1:0]            hit_idx
);
  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = 0; i < N; i++) begin
      if ((FW'(i) < fill) && (pages[i] == key) && !hit) begin
        hit     = 1'b1;
        hit_idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/hpt_min_find.sv
// Smallest counter; strict compare keeps the lowest index on ties.
module hpt_min_find #(
  parameter int N     = 8,
  parameter int CNT_W = 16,
  localparam int IW   = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0][CNT_W-1:0] cnts,
  output logic [IW-1:0]           min_idx,
  output logic [CNT_W-1:0]        min_cnt
);
  always_comb begin
    min_idx = '0;
    min_cnt = cnts[0];
    for (int i = 1; i < N; i++) begin
      if (cnts[i] < min_cnt) begin
        min_idx = IW'(i);
        min_cnt = cnts[i];
      end
    end
  end
endmodule

// File: rtl/hot_page_tracker.sv
module hot_page_tracker #(
  parameter int PRI_N  = 8,
  parameter int SEC_N  = 8,
  parameter int PAGE_W = 20,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_valid,
  input  logic [PAGE_W-1:0] acc_page,
  input  logic              period_end,
  output logic              ready,
  output logic              rpt_valid,
  output logic [PAGE_W-1:0] rpt_page,
  output logic              rpt_last
);
  import hpt_pkg::*;

  localparam int PIW = (PRI_N > 1) ? $clog2(PRI_N) : 1;
  localparam int PFW = $clog2(PRI_N + 1);
  localparam int SIW = (SEC_N > 1) ? $clog2(SEC_N) : 1;
  localparam int SFW = $clog2(SEC_N + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  hpt_state_t state;
  logic [PAGE_W-1:0] key_q;
  logic [PRI_N-1:0][PAGE_W-1:0] pri_page, p_nxt_page;
  logic [PRI_N-1:0][CNT_W-1:0]  pri_cnt,  p_nxt_cnt;
  logic [SEC_N-1:0][PAGE_W-1:0] sec_page, s_nxt_page;
  logic [SEC_N-1:0][CNT_W-1:0]  sec_cnt,  s_nxt_cnt;
  logic [PFW-1:0] pri_fill, p_nxt_fill;
  logic [SFW-1:0] sec_fill, s_nxt_fill;
  logic [PIW-1:0] rpt_idx;
  logic           rpt_final;

  logic           p_hit, s_hit;
  logic [PIW-1:0] p_hit_idx, p_min_idx;
  logic [SIW-1:0] s_hit_idx;
  logic [CNT_W-1:0] p_min_cnt, ins_cnt;

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] c);
    return (c == CNT_MAX) ? c : c + CNT_ONE;
  endfunction

  hpt_match #(.N(PRI_N), .PAGE_W(PAGE_W)) u_pri_match (
    .pages(pri_page), .fill(pri_fill), .key(key_q),
    .hit(p_hit), .hit_idx(p_hit_idx)
  );

  hpt_match #(.N(SEC_N), .PAGE_W(PAGE_W)) u_sec_match (
    .pages(sec_page), .fill(sec_fill), .key(key_q),
    .hit(s_hit), .hit_idx(s_hit_idx)
  );

  hpt_min_find #(.N(PRI_N), .CNT_W(CNT_W)) u_pri_min (
    .cnts(pri_cnt), .min_idx(p_min_idx), .min_cnt(p_min_cnt)
  );

  // Full update of both tables for the latched page, including any swap.
  always_comb begin
    p_nxt_page = pri_page;
    p_nxt_cnt  = pri_cnt;
    p_nxt_fill = pri_fill;
    s_nxt_page = sec_page;
    s_nxt_cnt  = sec_cnt;
    s_nxt_fill = sec_fill;
    ins_cnt    = CNT_ONE;
    if (p_hit) begin
      p_nxt_cnt[p_hit_idx] = sat_inc(pri_cnt[p_hit_idx]);
    end else if (pri_fill < PFW'(PRI_N)) begin
      p_nxt_page[PIW'(pri_fill)] = key_q;
      p_nxt_cnt[PIW'(pri_fill)]  = CNT_ONE;
      p_nxt_fill                 = pri_fill + PFW'(1);
    end else begin
      ins_cnt = s_hit ? sat_inc(sec_cnt[s_hit_idx]) : CNT_ONE;
      for (int i = 1; i < SEC_N; i++) begin
        if (!s_hit || (SIW'(i) <= s_hit_idx)) begin
          s_nxt_page[i] = sec_page[i-1];
          s_nxt_cnt[i]  = sec_cnt[i-1];
        end
      end
      if (!s_hit && (sec_fill != SFW'(SEC_N))) begin
        s_nxt_fill = sec_fill + SFW'(1);
      end
      if (ins_cnt >= p_min_cnt) begin
        p_nxt_page[p_min_idx] = key_q;
        p_nxt_cnt[p_min_idx]  = ins_cnt;
        s_nxt_page[0]         = pri_page[p_min_idx];
        s_nxt_cnt[0]          = pri_cnt[p_min_idx];
      end else begin
        s_nxt_page[0] = key_q;
        s_nxt_cnt[0]  = ins_cnt;
      end
    end
  end

  assign rpt_final = ((PFW'(rpt_idx) + PFW'(1)) == pri_fill);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      ready     <= 1'b1;
      rpt_valid <= 1'b0;
      rpt_last  <= 1'b0;
      rpt_page  <= '0;
      rpt_idx   <= '0;
      key_q     <= '0;
      pri_fill  <= '0;
      sec_fill  <= '0;
      pri_cnt   <= '0;
      sec_cnt   <= '0;
    end else begin
      rpt_valid <= 1'b0;
      rpt_last  <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (period_end) begin
            if (pri_fill != '0) begin
              state   <= ST_RPT;
              ready   <= 1'b0;
              rpt_idx <= '0;
            end else begin
              sec_cnt <= '0;
            end
          end else if (acc_valid) begin
            key_q <= acc_page;
            state <= ST_UPD;
            ready <= 1'b0;
          end
        end
        ST_UPD: begin
          pri_cnt  <= p_nxt_cnt;
          sec_cnt  <= s_nxt_cnt;
          pri_fill <= p_nxt_fill;
          sec_fill <= s_nxt_fill;
          state    <= ST_IDLE;
          ready    <= 1'b1;
        end
        ST_RPT: begin
          rpt_valid <= 1'b1;
          rpt_page  <= pri_page[rpt_idx];
          rpt_last  <= rpt_final;
          rpt_idx   <= rpt_idx + PIW'(1);
          if (rpt_final) begin
            pri_cnt <= '0;
            sec_cnt <= '0;
            state   <= ST_IDLE;
            ready   <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Page storage carries no reset; fill levels guard every read.
  always_ff @(posedge clk) begin
    if (state == ST_UPD) begin
      pri_page <= p_nxt_page;
      sec_page <= s_nxt_page;
    end
  end
endmodule

// File: rtl/hot_page_tracker_chk.sv
module hot_page_tracker_chk (
  input logic clk,
  input logic rst,
  input logic acc_valid,
  input logic period_end,
  input logic ready,
  input logic rpt_valid,
  input logic rpt_last
);
  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ready && !rpt_valid));

  assert_busy_after_accept_R10: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && ready && !period_end) |=> !ready);

  assert_ready_back_R10: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && ready && !period_end) |-> ##2 ready);

  assert_report_holds_off_R10: assert property (@(posedge clk) disable iff (rst)
    (rpt_valid && !rpt_last) |-> !ready);

  assert_last_in_beat_R7: assert property (@(posedge clk) disable iff (rst)
    rpt_last |-> rpt_valid);

  assert_beats_contiguous_R7: assert property (@(posedge clk) disable iff (rst)
    (rpt_valid && !rpt_last) |=> rpt_valid);
endmodule

bind hot_page_tracker hot_page_tracker_chk u_chk (
  .clk(clk), .rst(rst), .acc_valid(acc_valid), .period_end(period_end),
  .ready(ready), .rpt_valid(rpt_valid), .rpt_last(rpt_last)
);

// File: tb/hot_page_tracker_tb.sv
`timescale 1ns/1ps
module hot_page_tracker_tb;
  localparam int PRI  = 4;
  localparam int SEC  = 3;
  localparam int PW   = 20;
  localparam int CW   = 4;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic acc_valid = 1'b0;
  logic [PW-1:0] acc_page = '0;
  logic period_end = 1'b0;
  logic ready, rpt_valid, rpt_last;
  logic [PW-1:0] rpt_page;

  int checks = 0;
  int fails  = 0;

  int mp[PRI]; int mc[PRI]; int mfill;
  int sp[SEC]; int sc[SEC]; int sfill;

  always #2.5 clk = ~clk;

  hot_page_tracker #(.PRI_N(PRI), .SEC_N(SEC), .PAGE_W(PW), .CNT_W(CW)) u_dut (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_page(acc_page),
    .period_end(period_end), .ready(ready), .rpt_valid(rpt_valid),
    .rpt_page(rpt_page), .rpt_last(rpt_last)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int sat(input int c);
    return (c >= CMAX) ? CMAX : c + 1;
  endfunction

  // Bench model of the table rules (R2..R6, R9).
  task automatic model_access(input int p);
    int hi, si, nc, mi, tp, tc;
    hi = -1;
    for (int i = 0; i < mfill; i++) if (mp[i] == p) hi = i;
    if (hi >= 0) begin
      mc[hi] = sat(mc[hi]);
    end else if (mfill < PRI) begin
      mp[mfill] = p; mc[mfill] = 1; mfill++;
    end else begin
      si = -1;
      for (int i = 0; i < sfill; i++) if (sp[i] == p) si = i;
      if (si >= 0) begin
        nc = sat(sc[si]);
        for (int k = si; k > 0; k--) begin sp[k] = sp[k-1]; sc[k] = sc[k-1]; end
      end else begin
        nc = 1;
        if (sfill < SEC) sfill++;
        for (int k = sfill - 1; k > 0; k--) begin sp[k] = sp[k-1]; sc[k] = sc[k-1]; end
      end
      sp[0] = p; sc[0] = nc;
      mi = 0;
      for (int i = 1; i < PRI; i++) if (mc[i] < mc[mi]) mi = i;
      if (nc >= mc[mi]) begin
        tp = mp[mi]; tc = mc[mi];
        mp[mi] = p; mc[mi] = nc;
        sp[0] = tp; sc[0] = tc;
      end
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    mfill = 0; sfill = 0;
    @(negedge clk);
    check(ready === 1'b1, "R1 ready after reset", int'(ready), 1);
    check(rpt_valid === 1'b0, "R1 no report after reset", int'(rpt_valid), 0);
  endtask

  task automatic do_access(input int p, input bit chk_rdy);
    @(negedge clk);
    while (!ready) @(negedge clk);
    acc_valid = 1'b1; acc_page = PW'(p);
    @(negedge clk);
    acc_valid = 1'b0;
    if (chk_rdy) check(ready === 1'b0, "R10 busy after accept", int'(ready), 0);
    model_access(p);
  endtask

  task automatic collect_report(input string tag, input bit with_acc, input int acc_p);
    int got[PRI+3]; int n; int last_at; bit bad; int bad_a, bad_e;
    @(negedge clk);
    while (!ready) @(negedge clk);
    period_end = 1'b1;
    if (with_acc) begin acc_valid = 1'b1; acc_page = PW'(acc_p); end
    @(negedge clk);
    period_end = 1'b0; acc_valid = 1'b0;
    n = 0; last_at = -1;
    for (int c = 0; c < PRI + 3; c++) begin
      @(negedge clk);
      if (rpt_valid) begin
        got[n] = int'(rpt_page);
        if (rpt_last) last_at = n;
        n++;
        if (rpt_last) break;
      end
    end
    check(n == mfill, {tag, " R7 beat count"}, n, mfill);
    if (mfill == 0) check(ready === 1'b1, {tag, " R1 empty report"}, int'(ready), 1);
    else check(last_at == mfill - 1, {tag, " R7 last flag"}, last_at, mfill - 1);
    bad = 0; bad_a = 0; bad_e = 0;
    for (int i = 0; i < n && i < mfill; i++)
      if (got[i] != mp[i] && !bad) begin bad = 1; bad_a = got[i]; bad_e = mp[i]; end
    check(!bad, {tag, " R2 R6 reported pages"}, bad_a, bad_e);
    for (int i = 0; i < PRI; i++) mc[i] = 0;
    for (int i = 0; i < SEC; i++) sc[i] = 0;
  endtask

  initial begin
    #(5.0 * 200000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    do_reset();
    // R1: end of period with empty tables
    collect_report("empty", 1'b0, 0);

    // R2 R3 R6: fill, hit, tie displaces lowest slot -> expect 1,5,3,4
    for (int p = 1; p <= 4; p++) do_access(p, 1'b1);
    do_access(1, 1'b1);
    do_access(5, 1'b1);
    collect_report("tie", 1'b0, 0);
    // R8: counts zero, pages kept -> access 6 displaces slot 0 -> 6,5,3,4
    do_access(6, 1'b0);
    collect_report("clear", 1'b0, 0);

    // R9: saturation prevents a weak page from displacing a busy one
    do_reset();
    for (int r = 0; r < 17; r++) do_access(1, 1'b0);
    for (int p = 2; p <= 4; p++) for (int r = 0; r < 20; r++) do_access(p, 1'b0);
    for (int r = 0; r < 14; r++) do_access(5, 1'b0);
    collect_report("R9 sat", 1'b0, 0);

    // R4 R5: recency move on hit and LRU eviction -> page 6 promoted
    do_reset();
    for (int p = 1; p <= 4; p++) for (int r = 0; r < 3; r++) do_access(p, 1'b0);
    do_access(6, 1'b0); do_access(7, 1'b0); do_access(8, 1'b0);
    do_access(6, 1'b0); do_access(9, 1'b0); do_access(7, 1'b0);
    do_access(6, 1'b0);
    collect_report("R4 R5 lru", 1'b0, 0);

    // R10: simultaneous end-of-period and access, the access is not taken
    do_reset();
    for (int p = 1; p <= 3; p++) do_access(p, 1'b0);
    collect_report("R10 both", 1'b1, 9);
    do_access(10, 1'b0);
    collect_report("R10 after", 1'b0, 0);

    // Random traffic against the model
    do_reset();
    for (int i = 0; i < 1500; i++) begin
      do_access(int'($urandom % 10), (i % 50) == 0);
      if (($urandom % 30) == 0) collect_report("random", 1'b0, 0);
    end
    collect_report("random end", 1'b0, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule